// File: doc/BRIEF.md
# Memory current-test pattern generator

This block drives the command, address and data pins of a DDR3-style memory with the fixed, repeating activity needed to hold the device in a known supply-current measurement state. Every output is a register on one single-rate clock. Data pins are given as one value for each of the two transfers within a clock.

Time is cut into blocks of four clocks. All address and bank bits flip together at the start of a block. The command stream runs a background in which each of two encodings is held for two clocks in turn. Real ACTIVATE and READ commands are placed into that background by two interval timers that can be set independently. A mode input picks idle, command/address switching only, or full switching with data. The block applies the mode input only at a block boundary, so a pattern never changes partway through a block.

Top module: `icc_pattern_gen`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: address and bank all zero, command {cs_n,ras_n,cas_n,we_n} = 4'b1111, DQ all zero on both transfers, both DQS transfers low, and DM zero. The block cycle restarts at its first clock.
- R2: `mode_i` is sampled only in the last clock of a 4-clock block and takes effect from the first clock of the next block. The encodings are 2'b00 for idle, 2'b01 for command/address switching, and 2'b10 or 2'b11 for full switching. Idle drives command 4'b1111 on every clock.
- R3: In a non-idle mode, every address bit inverts at the first clock of each block and then holds for 4 clocks. In idle the address keeps its last value.
- R4: The bank bits invert and hold on exactly the same clocks as the address bits.
- R5: In a non-idle mode with nothing inserted, the command is 4'b1000 in block clocks 0 and 1 and 4'b1111 in block clocks 2 and 3.
- R6: With `act_ivl_i` = N > 0, ACTIVATE (4'b0011) replaces the command on every N-th non-idle clock. The count starts from entry into a non-idle mode or from the previous insertion. If the count already reaches N-1 when N is lowered, the insertion happens on the next clock. N = 0 disables ACTIVATE insertion and clears its count.
- R7: With `rd_ivl_i` = M > 0, READ (4'b0101) is inserted on the same counting rule as R6. M = 0 disables READ insertion.
- R8: When both insertions fall on the same clock, ACTIVATE is driven. The READ count still restarts, so that READ slot is lost.
- R9: In full mode, both DQ transfers carry the same value, and the whole bus inverts every clock. The first full clock after a non-full clock is all ones. In other modes DQ is all zero.
- R10: In full mode, DQS is high on the first transfer and low on the second transfer of every clock. In other modes both DQS transfers are low.
- R11: DM is zero on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Requested pattern mode |
| act_ivl_i | input | IVL_W | ACTIVATE insertion interval in clocks, 0 disables |
| rd_ivl_i | input | IVL_W | READ insertion interval in clocks, 0 disables |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ROW_W | Row/column address |
| bank_o | output | BANK_W | Bank address |
| dq_t0_o | output | DQ_W | DQ, first transfer of the clock |
| dq_t1_o | output | DQ_W | DQ, second transfer of the clock |
| dqs_t0_o | output | 1 | DQS, first transfer |
| dqs_t1_o | output | 1 | DQS, second transfer |
| dm_o | output | DM_W | Data mask |

## Verification
The bench builds the block with its default widths: 14 address bits, 3 bank bits, 8 DQ bits and 8-bit intervals. These widths make a full inversion visible on every bus. With small interval values the bench reaches an insertion on every clock, intervals that are not multiples of the block length, and ACTIVATE/READ collisions at the least common multiple of the two intervals. Mode requests are changed in the middle of blocks so that the boundary-only rule is exercised from every block position.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_CA   = 2'd1,
    MD_FULL = 2'd2
  } md_e;

  typedef logic [3:0] cmd_t;  // {cs_n, ras_n, cas_n, we_n}

  localparam cmd_t CMD_BG_A = 4'b1000;
  localparam cmd_t CMD_NOP  = 4'b1111;
  localparam cmd_t CMD_ACT  = 4'b0011;
  localparam cmd_t CMD_RD   = 4'b0101;

  function automatic md_e md_decode(input logic [1:0] m);
    case (m)
      2'b00:   return MD_IDLE;
      2'b01:   return MD_CA;
      default: return MD_FULL;
    endcase
  endfunction
endpackage

// File: rtl/icc_phase_ctrl.sv
module icc_phase_ctrl
  import icc_pkg::*;
#(
  parameter int HOLD_CLKS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   mode_i,
  output md_e                          md_n_o,
  output logic [$clog2(HOLD_CLKS)-1:0] cnt_n_o,
  output logic                         blk_o
);
  localparam int CW = $clog2(HOLD_CLKS);
  localparam logic [CW-1:0] C_ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_n;
  md_e           md_q, md_n;
  logic          blk;

  always_comb begin
    blk   = &cnt_q;
    cnt_n = cnt_q + C_ONE;
    md_n  = blk ? md_decode(mode_i) : md_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      md_q  <= MD_IDLE;
    end else begin
      cnt_q <= cnt_n;
      md_q  <= md_n;
    end
  end

  assign md_n_o  = md_n;
  assign cnt_n_o = cnt_n;
  assign blk_o   = blk;
endmodule

// File: rtl/icc_toggler.sv
module icc_toggler #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flip_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_n;

  always_comb q_n = flip_i ? ~q_q : q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_n;
  end

  assign q_o = q_q;
endmodule

// File: rtl/icc_ivl_timer.sv
module icc_ivl_timer #(
  parameter int IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             fire_o
);
  localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

  logic [IVL_W-1:0] cnt_q, cnt_n;

  always_comb begin
    fire_o = 1'b0;
    cnt_n  = '0;
    if (en_i && (ivl_i != '0)) begin
      if (cnt_q >= (ivl_i - ONE)) fire_o = 1'b1;
      else                        cnt_n  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/icc_data_gen.sv
module icc_data_gen #(
  parameter int DQ_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            full_i,
  output logic [DQ_W-1:0] dq_o,
  output logic [1:0]      dqs_o
);
  logic [DQ_W-1:0] dq_q, dq_n;
  logic [1:0]      dqs_q, dqs_n;

  always_comb begin
    dq_n  = full_i ? ~dq_q : '0;
    dqs_n = full_i ? 2'b10 : 2'b00;  // {first transfer, second transfer}
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q  <= '0;
      dqs_q <= 2'b00;
    end else begin
      dq_q  <= dq_n;
      dqs_q <= dqs_n;
    end
  end

  assign dq_o  = dq_q;
  assign dqs_o = dqs_q;
endmodule

// File: rtl/icc_pattern_gen.sv
module icc_pattern_gen
  import icc_pkg::*;
#(
  parameter int ROW_W     = 14,
  parameter int BANK_W    = 3,
  parameter int DQ_W      = 8,
  parameter int IVL_W     = 8,
  parameter int HOLD_CLKS = 4,   // power of two, at least 4
  localparam int DM_W     = (DQ_W + 7) / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [IVL_W-1:0]  act_ivl_i,
  input  logic [IVL_W-1:0]  rd_ivl_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [DQ_W-1:0]   dq_t0_o,
  output logic [DQ_W-1:0]   dq_t1_o,
  output logic              dqs_t0_o,
  output logic              dqs_t1_o,
  output logic [DM_W-1:0]   dm_o
);
  localparam int CW    = $clog2(HOLD_CLKS);
  localparam int N_INS = 2;  // slot 0 ACTIVATE (wins), slot 1 READ

  md_e                       md_n;
  logic [CW-1:0]             cnt_n;
  logic                      blk;
  logic                      active_n;
  logic                      flip;
  logic [N_INS-1:0]          fire;
  logic [N_INS-1:0][IVL_W-1:0] ivl;
  logic [DQ_W-1:0]           dq;
  logic [1:0]                dqs;
  cmd_t                      cmd_q, cmd_n;

  icc_phase_ctrl #(.HOLD_CLKS(HOLD_CLKS)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .md_n_o (md_n),
    .cnt_n_o(cnt_n),
    .blk_o  (blk)
  );

  assign active_n = (md_n != MD_IDLE);
  assign flip     = blk & active_n;

  icc_toggler #(.W(ROW_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .flip_i(flip), .q_o(addr_o)
  );

  icc_toggler #(.W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .flip_i(flip), .q_o(bank_o)
  );

  assign ivl[0] = act_ivl_i;
  assign ivl[1] = rd_ivl_i;

  for (genvar g = 0; g < N_INS; g++) begin : g_ins
    icc_ivl_timer #(.IVL_W(IVL_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (active_n),
      .ivl_i (ivl[g]),
      .fire_o(fire[g])
    );
  end

  always_comb begin
    if (!active_n)    cmd_n = CMD_NOP;
    else if (fire[0]) cmd_n = CMD_ACT;
    else if (fire[1]) cmd_n = CMD_RD;
    else              cmd_n = cnt_n[1] ? CMD_NOP : CMD_BG_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= CMD_NOP;
    else        cmd_q <= cmd_n;
  end

  icc_data_gen #(.DQ_W(DQ_W)) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .full_i(md_n == MD_FULL),
    .dq_o  (dq),
    .dqs_o (dqs)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign dq_t0_o  = dq;
  assign dq_t1_o  = dq;
  assign dqs_t0_o = dqs[1];
  assign dqs_t1_o = dqs[0];
  assign dm_o     = '0;
endmodule

// File: rtl/icc_pattern_gen_chk.sv
module icc_pattern_gen_chk #(
  parameter int ROW_W  = 14,
  parameter int BANK_W = 3,
  parameter int DQ_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [ROW_W-1:0]  addr_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [DQ_W-1:0]   dq_t0_o,
  input logic [DQ_W-1:0]   dq_t1_o,
  input logic              dqs_t0_o
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r3_addr_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (addr_o != $past(addr_o))) |-> (addr_o == ~$past(addr_o)));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (addr_o != $past(addr_o))) |=> $stable(addr_o));

  a_r4_bank_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (addr_o != $past(addr_o))) |-> (bank_o == ~$past(bank_o)));

  a_r9_dq_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dqs_t0_o) |-> ((dq_t0_o == ~$past(dq_t0_o)) && (dq_t1_o == dq_t0_o)));

  a_r10_dq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dqs_t0_o |-> (dq_t0_o == '0));

  a_r5_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n_o, ras_n_o, cas_n_o, we_n_o} inside {4'b1000, 4'b1111, 4'b0011, 4'b0101}));
endmodule

bind icc_pattern_gen icc_pattern_gen_chk #(
  .ROW_W(ROW_W), .BANK_W(BANK_W), .DQ_W(DQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
  .addr_o(addr_o), .bank_o(bank_o),
  .dq_t0_o(dq_t0_o), .dq_t1_o(dq_t1_o), .dqs_t0_o(dqs_t0_o)
);

// File: tb/icc_pattern_gen_tb.sv
module icc_pattern_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 14;
  localparam int BANK_W = 3;
  localparam int DQ_W   = 8;
  localparam int IVL_W  = 8;
  localparam int DM_W   = 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode_i = 2'b10;
  logic [IVL_W-1:0]  act_ivl_i = 8'd1;
  logic [IVL_W-1:0]  rd_ivl_i = 8'd1;
  logic              cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [ROW_W-1:0]  addr_o;
  logic [BANK_W-1:0] bank_o;
  logic [DQ_W-1:0]   dq_t0_o, dq_t1_o;
  logic              dqs_t0_o, dqs_t1_o;
  logic [DM_W-1:0]   dm_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  icc_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .act_ivl_i(act_ivl_i), .rd_ivl_i(rd_ivl_i),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .addr_o(addr_o), .bank_o(bank_o),
    .dq_t0_o(dq_t0_o), .dq_t1_o(dq_t1_o),
    .dqs_t0_o(dqs_t0_o), .dqs_t1_o(dqs_t1_o), .dm_o(dm_o)
  );

  typedef struct {
    logic [3:0]        cmd;
    string             ctag;
    logic [ROW_W-1:0]  addr;
    logic [BANK_W-1:0] bank;
    logic [DQ_W-1:0]   dq;
    logic [1:0]        dqs;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;

  // reference state, kept from the requirements
  int                m_pos;
  int                m_md;
  logic [ROW_W-1:0]  m_addr;
  logic [BANK_W-1:0] m_bank;
  logic [DQ_W-1:0]   m_dq;
  int                m_ta, m_tr;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // one clock of stimulus: set inputs, predict the result after the next edge
  task automatic drive(int n, logic [1:0] md, int act, int rd);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int   req;
      bit   blk, on, fa, fr;
      mode_i    = md;
      act_ivl_i = IVL_W'(act);
      rd_ivl_i  = IVL_W'(rd);
      req = (md == 2'b00) ? 0 : (md == 2'b01) ? 1 : 2;
      blk = (m_pos == 3);
      if (blk) m_md = req;                      // R2
      m_pos = (m_pos + 1) % 4;
      on = (m_md != 0);
      if (blk && on) begin                      // R3, R4
        m_addr = ~m_addr;
        m_bank = ~m_bank;
      end
      fa = 0; fr = 0;
      if (on && act != 0) begin                 // R6
        if (m_ta >= act - 1) begin fa = 1; m_ta = 0; end else m_ta++;
      end else m_ta = 0;
      if (on && rd != 0) begin                  // R7
        if (m_tr >= rd - 1) begin fr = 1; m_tr = 0; end else m_tr++;
      end else m_tr = 0;
      if (!on)     begin e.cmd = 4'b1111; e.ctag = "R2"; end
      else if (fa) begin e.cmd = 4'b0011; e.ctag = fr ? "R8" : "R6"; end
      else if (fr) begin e.cmd = 4'b0101; e.ctag = "R7"; end
      else         begin e.cmd = (m_pos < 2) ? 4'b1000 : 4'b1111; e.ctag = "R5"; end
      if (req != m_md) e.ctag = "R2";           // mode request still pending
      if (m_md == 2) begin m_dq = ~m_dq; e.dqs = 2'b10; end   // R9, R10
      else           begin m_dq = '0;    e.dqs = 2'b00; end
      e.addr = m_addr;
      e.bank = m_bank;
      e.dq   = m_dq;
      exp_q.push_back(e);
      @(negedge clk);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      chk(e.ctag, "cmd", 32'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 32'(e.cmd));
      chk("R3", "addr", 32'(addr_o), 32'(e.addr));
      chk("R4", "bank", 32'(bank_o), 32'(e.bank));
      chk("R9", "dq_t0", 32'(dq_t0_o), 32'(e.dq));
      chk("R9", "dq_t1", 32'(dq_t1_o), 32'(e.dq));
      chk("R10", "dqs", 32'({dqs_t0_o, dqs_t1_o}), 32'(e.dqs));
      chk("R11", "dm", 32'(dm_o), 32'd0);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while rst_n is held low with non-idle inputs
    n_vec++;
    chk("R1", "cmd", 32'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 32'hF);
    chk("R1", "addr", 32'(addr_o), 32'd0);
    chk("R1", "bank", 32'(bank_o), 32'd0);
    chk("R1", "dq", 32'(dq_t0_o | dq_t1_o), 32'd0);
    chk("R1", "dqs", 32'({dqs_t0_o, dqs_t1_o}), 32'd0);
    chk("R1", "dm", 32'(dm_o), 32'd0);
    m_pos = 0; m_md = 0; m_addr = '0; m_bank = '0; m_dq = '0; m_ta = 0; m_tr = 0;
    rst_n = 1'b1;
    drive(8, 2'b00, 0, 0);      // R2 idle, first block
    drive(12, 2'b01, 0, 0);     // R5 background, R3/R4 flips
    drive(10, 2'b01, 5, 0);     // R6 interval not a block multiple
    drive(3, 2'b10, 0, 3);      // R2 mid-block request
    drive(16, 2'b10, 0, 3);     // R7, R9, R10
    drive(20, 2'b11, 4, 2);     // R8 collisions, mode 11 as full
    drive(8, 2'b10, 1, 0);      // R6 every clock
    drive(2, 2'b10, 0, 0);      // R6 zero disables
    drive(10, 2'b00, 3, 3);     // R3 hold in idle, inserts ignored
    drive(9, 2'b01, 0, 1);      // R7 every clock, R9 data quiet
    drive(6, 2'b10, 0, 0);
    @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule